// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

This block is a clocked, counter-based one-shot. It produces a single high pulse on `q_out` that lasts a programmed number of clock cycles, and it drives the inverse of that pulse on `qn_out`. A pulse can be started in three ways. The first is a falling edge on `fall_trig`. The second is a rising edge on `rise_trig`. The third is the release of the active-low `clear_n` input. Each of these edges only counts when the other inputs are in their enabling levels. If a valid trigger arrives while a pulse is running, the count reloads to the full width. A steady stream of triggers can therefore keep the output high for as long as it continues.

All three control inputs are asynchronous to `clk`. Each one passes through a two-flop synchroniser and then an edge detector. A gate stage combines the detected edges and levels into one `fire` strobe per cycle. A timer state machine has three states: `ST_IDLE`, `ST_PULSE` and `ST_HELD`. It loads a down-counter from `width_in` on `fire`. Its transitions are:
- IDLE→PULSE on a fire with non-zero width.
- PULSE→PULSE on a reload or a count step.
- PULSE→IDLE at terminal count, or on a fire with zero width.
- Any state→HELD while clear is low.
- HELD→PULSE on a fire with non-zero width when clear is released.
- HELD→IDLE on a release with no fire.

Two independent channels are made by instantiating the block twice.

Top module: `oneshot_pulse`

## Requirements
- R1: A falling edge on `fall_trig` starts a pulse only while `rise_trig` is high and `clear_n` is high.
- R2: A rising edge on `rise_trig` starts a pulse only while `fall_trig` is low and `clear_n` is high.
- R3: An edge on one trigger input is ignored when the other trigger input is not at its enabling level. A rising `fall_trig` or a falling `rise_trig` never triggers.
- R4: The pulse is high for exactly `width_in` clock cycles. `q_out` rises in the third clock cycle after the input change, counting two synchroniser stages and one state register. `width_in` is sampled only in the cycle the trigger loads the counter.
- R5: A valid trigger during a pulse reloads the full width. Triggers spaced closer than the width hold `q_out` high continuously.
- R6: Holding `clear_n` low ends a running pulse, with `q_out` low three cycles after the input falls. All triggers are ignored while `clear_n` stays low.
- R7: A rising edge on `clear_n` starts a pulse when `fall_trig` is low and `rise_trig` is high.
- R8: A trigger with `width_in` equal to zero produces no pulse. Such a trigger during a running pulse ends that pulse at its load cycle.
- R9: Trigger conditions that occur in the same cycle cause a single load of the counter, so the pulse is exactly one width long.
- R10: `qn_out` is always the inverse of `q_out`.
- R11: Asserting `rst_n` low clears the block at once: `q_out` is low and `qn_out` is high, independent of the clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling and counting clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| fall_trig | input | 1 | Trigger on falling edge, asynchronous |
| rise_trig | input | 1 | Trigger on rising edge, asynchronous |
| clear_n | input | 1 | Direct clear, active low; its rising edge can also trigger |
| width_in | input | CNT_W | Pulse length in clock cycles |
| q_out | output | 1 | Pulse output, active high |
| qn_out | output | 1 | Inverse of `q_out` |

## Verification
The timer assertions assume that `fire` is only ever raised while the synchronised clear level is high. They also assume that `width_in` is stable in the cycle it is loaded, so the count after a load can be related to its past value. The stimulus changes inputs one clock after a rising edge. It holds `width_in` steady across each load cycle and changes it only after the load edge in the sampling test. Every trigger input is held for at least two clock cycles, so the synchronisers never miss a level.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_HELD  = 2'd2
    } os_state_e;

    localparam int IN_NUM = 3;
    localparam int IN_FALL = 0;
    localparam int IN_RISE = 1;
    localparam int IN_CLR = 2;

    // quiet levels: fall trigger high, rise trigger low, clear released
    localparam logic [IN_NUM-1:0] IN_IDLE_LVL = 3'b101;

endpackage

// File: rtl/os_sync.sv
module os_sync #(
    parameter int N = 3,
    parameter int STAGES = 2,
    parameter logic [N-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] sync_o
);

    logic [N-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= INIT;
                    else        chain_q[s] <= raw_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= INIT;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/os_edge.sv
module os_edge #(
    parameter int N = 3,
    parameter logic [N-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= INIT;
        else        prev_q <= lvl_i;
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            always_comb begin
                rise_o[i] = lvl_i[i] & ~prev_q[i];
                fall_o[i] = ~lvl_i[i] & prev_q[i];
            end
        end
    endgenerate

endmodule

// File: rtl/os_gate.sv
module os_gate
    import oneshot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IN_NUM-1:0] lvl_i,
    input  logic [IN_NUM-1:0] rise_i,
    input  logic [IN_NUM-1:0] fall_i,
    output logic              fire_o
);

    logic hit_fall, hit_rise, hit_clr;

    always_comb begin
        hit_fall = fall_i[IN_FALL] & lvl_i[IN_RISE] & lvl_i[IN_CLR];
        hit_rise = rise_i[IN_RISE] & ~lvl_i[IN_FALL] & lvl_i[IN_CLR];
        hit_clr  = rise_i[IN_CLR] & ~lvl_i[IN_FALL] & lvl_i[IN_RISE];
        fire_o   = hit_fall | hit_rise | hit_clr;
    end

    // R3: a falling edge with the rise input low never fires
    assert_fall_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_i[IN_FALL] && !lvl_i[IN_RISE] && !rise_i[IN_CLR]) |-> !fire_o);

    // R6: nothing fires while clear is low
    assert_clear_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_i[IN_CLR] |-> !fire_o);

endmodule

// File: rtl/os_timer.sv
module os_timer
    import oneshot_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  logic             clr_lvl_i,
    input  logic [CNT_W-1:0] width_i,
    output logic             pulse_o,
    output logic             pulse_n_o
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    os_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             width_zero;

    always_comb width_zero = (width_i == CNT_ZERO);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= CNT_ZERO;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!clr_lvl_i) begin
                    state_d = ST_HELD;
                end else if (fire_i && !width_zero) begin
                    state_d = ST_PULSE;
                    cnt_d   = width_i - CNT_ONE;
                end
            end
            ST_PULSE: begin
                if (!clr_lvl_i) begin
                    state_d = ST_HELD;
                    cnt_d   = CNT_ZERO;
                end else if (fire_i) begin
                    if (width_zero) begin
                        state_d = ST_IDLE;
                        cnt_d   = CNT_ZERO;
                    end else begin
                        cnt_d = width_i - CNT_ONE;
                    end
                end else if (cnt_q == CNT_ZERO) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - CNT_ONE;
                end
            end
            ST_HELD: begin
                if (!clr_lvl_i) begin
                    state_d = ST_HELD;
                end else if (fire_i && !width_zero) begin
                    state_d = ST_PULSE;
                    cnt_d   = width_i - CNT_ONE;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = CNT_ZERO;
            end
        endcase
    end

    always_comb begin
        pulse_o   = (state_q == ST_PULSE);
        pulse_n_o = (state_q != ST_PULSE);
    end

    // R4: a load with non-zero width enters the pulse with width-1 left
    assert_load_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && !width_zero) |=> (state_q == ST_PULSE && cnt_q == $past(width_i) - CNT_ONE));

    // R4: without a trigger the count steps down by one
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE && !fire_i && clr_lvl_i && cnt_q != CNT_ZERO)
            |=> (state_q == ST_PULSE && cnt_q == $past(cnt_q) - CNT_ONE));

    // R4: terminal count ends the pulse
    assert_terminal_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE && !fire_i && clr_lvl_i && cnt_q == CNT_ZERO) |=> state_q == ST_IDLE);

    // R8: a zero-width trigger leaves no pulse
    assert_zero_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && width_zero) |=> !pulse_o);

    // R6: a low clear level forces the held state
    assert_clear_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_lvl_i |=> (state_q == ST_HELD));

    // R1: a pulse only begins after a fire
    assert_start_on_fire_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> $past(fire_i));

endmodule

// File: rtl/oneshot_pulse.sv
module oneshot_pulse
    import oneshot_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_trig,
    input  logic             rise_trig,
    input  logic             clear_n,
    input  logic [CNT_W-1:0] width_in,
    output logic             q_out,
    output logic             qn_out
);

    logic [IN_NUM-1:0] raw_in, lvl, rise, fall;
    logic              fire;

    always_comb begin
        raw_in           = '0;
        raw_in[IN_FALL]  = fall_trig;
        raw_in[IN_RISE]  = rise_trig;
        raw_in[IN_CLR]   = clear_n;
    end

    os_sync #(.N(IN_NUM), .STAGES(SYNC_STAGES), .INIT(IN_IDLE_LVL)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw_in),
        .sync_o (lvl)
    );

    os_edge #(.N(IN_NUM), .INIT(IN_IDLE_LVL)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    os_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl),
        .rise_i (rise),
        .fall_i (fall),
        .fire_o (fire)
    );

    os_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire_i    (fire),
        .clr_lvl_i (lvl[IN_CLR]),
        .width_i   (width_in),
        .pulse_o   (q_out),
        .pulse_n_o (qn_out)
    );

    // R11: reset holds the output low
    assert_reset_low_R11: assert property (@(posedge clk) !rst_n |-> !q_out);

endmodule

// File: tb/oneshot_pulse_test.sv
module oneshot_pulse_test;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 8;

    typedef struct {
        bit    val;
        string tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             fall_trig, rise_trig, clear_n;
    logic [CNT_W-1:0] width_in;
    logic             q_out, qn_out;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t expq[$];

    oneshot_pulse #(.CNT_W(CNT_W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_trig (fall_trig),
        .rise_trig (rise_trig),
        .clear_n   (clear_n),
        .width_in  (width_in),
        .q_out     (q_out),
        .qn_out    (qn_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic push(input bit v, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.val = v;
            e.tag = tag;
            expq.push_back(e);
        end
    endtask

    task automatic adv(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // monitor: pops one expectation per cycle
    initial begin
        forever begin
            @(negedge clk);
            if (expq.size() > 0) begin
                exp_t e;
                e = expq.pop_front();
                checks++;
                if (q_out !== e.val) begin
                    errors++;
                    $display("FAIL %s q_out=%b expected %b at %0t", e.tag, q_out, e.val, $time);
                end
                checks++;
                if (qn_out !== ~e.val) begin
                    errors++;
                    $display("FAIL R10 qn_out=%b expected %b at %0t", qn_out, ~e.val, $time);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    task automatic rest(input int n);
        fall_trig = 1'b1;
        rise_trig = 1'b0;
        push(1'b0, n, "rest");
        adv(n);
    endtask

    initial begin
        rst_n     = 1'b0;
        fall_trig = 1'b1;
        rise_trig = 1'b0;
        clear_n   = 1'b1;
        width_in  = 8'd5;
        repeat (3) @(posedge clk);
        #3;
        checks++;
        if (q_out !== 1'b0 || qn_out !== 1'b1) begin
            errors++;
            $display("FAIL R11 reset q=%b qn=%b expected 0 1", q_out, qn_out);
        end
        @(negedge clk);
        rst_n = 1'b1;
        adv(1);
        push(1'b0, 4, "R11");
        adv(4);

        // R3: rise input edge while fall input high is gated
        rise_trig = 1'b1;
        push(1'b0, 8, "R3");
        adv(8);
        // R1: falling edge with rise high
        fall_trig = 1'b0;
        push(1'b0, 3, "R1");
        push(1'b1, 5, "R1");
        push(1'b0, 4, "R1");
        adv(12);
        rest(6);

        // R3: fall edge with rise low is gated
        fall_trig = 1'b0;
        push(1'b0, 6, "R3");
        adv(6);
        // R2: rising edge with fall low
        rise_trig = 1'b1;
        push(1'b0, 3, "R2");
        push(1'b1, 5, "R2");
        push(1'b0, 4, "R2");
        adv(12);
        rest(6);

        // R4: widths 1 and 3
        for (int w = 1; w <= 3; w += 2) begin
            width_in  = CNT_W'(w);
            rise_trig = 1'b1;
            push(1'b0, 4, "R4");
            adv(4);
            fall_trig = 1'b0;
            push(1'b0, 3, "R4");
            push(1'b1, w, "R4");
            push(1'b0, 4, "R4");
            adv(7 + w);
            rest(4);
        end

        // R4: width changed after load has no effect
        width_in  = 8'd3;
        rise_trig = 1'b1;
        push(1'b0, 4, "R4");
        adv(4);
        fall_trig = 1'b0;
        push(1'b0, 3, "R4");
        push(1'b1, 3, "R4");
        push(1'b0, 6, "R4");
        adv(4);
        width_in = 8'd9;
        adv(8);
        rest(4);

        // R8: zero width gives no pulse
        width_in  = 8'd0;
        rise_trig = 1'b1;
        push(1'b0, 4, "R8");
        adv(4);
        fall_trig = 1'b0;
        push(1'b0, 10, "R8");
        adv(10);
        rest(4);

        // R5: single retrigger extends to 4 + 5 cycles
        width_in  = 8'd5;
        rise_trig = 1'b1;
        push(1'b0, 4, "R5");
        adv(4);
        fall_trig = 1'b0;
        push(1'b0, 3, "R5");
        push(1'b1, 9, "R5");
        push(1'b0, 4, "R5");
        adv(2);
        fall_trig = 1'b1;
        adv(2);
        fall_trig = 1'b0;
        adv(12);
        rest(4);

        // R5: continuous retriggering holds q high
        rise_trig = 1'b1;
        push(1'b0, 4, "R5");
        adv(4);
        fall_trig = 1'b0;
        push(1'b0, 3, "R5");
        push(1'b1, 45, "R5");
        push(1'b0, 4, "R5");
        for (int k = 0; k < 10; k++) begin
            adv(2);
            fall_trig = 1'b1;
            adv(2);
            fall_trig = 1'b0;
        end
        adv(12);
        rest(4);

        // R6: clear ends pulse and blocks triggers
        width_in  = 8'd10;
        rise_trig = 1'b1;
        push(1'b0, 4, "R6");
        adv(4);
        fall_trig = 1'b0;
        push(1'b0, 3, "R6");
        push(1'b1, 4, "R6");
        push(1'b0, 13, "R6");
        adv(4);
        clear_n = 1'b0;
        adv(4);
        fall_trig = 1'b1;
        adv(2);
        fall_trig = 1'b0;
        adv(2);
        fall_trig = 1'b1;
        adv(2);
        clear_n = 1'b1;
        adv(6);
        rest(4);

        // R7: clear release with fall low and rise high triggers
        width_in = 8'd5;
        clear_n  = 1'b0;
        push(1'b0, 8, "R7");
        adv(4);
        rise_trig = 1'b1;
        adv(2);
        fall_trig = 1'b0;
        adv(2);
        clear_n = 1'b1;
        push(1'b0, 3, "R7");
        push(1'b1, 5, "R7");
        push(1'b0, 4, "R7");
        adv(12);
        rest(4);

        // R9: fall edge and clear release in the same cycle
        clear_n   = 1'b0;
        rise_trig = 1'b1;
        push(1'b0, 4, "R9");
        adv(4);
        fall_trig = 1'b0;
        clear_n   = 1'b1;
        push(1'b0, 3, "R9");
        push(1'b1, 5, "R9");
        push(1'b0, 4, "R9");
        adv(12);
        rest(4);

        // R8: zero-width retrigger ends a running pulse
        width_in  = 8'd8;
        rise_trig = 1'b1;
        push(1'b0, 4, "R8");
        adv(4);
        fall_trig = 1'b0;
        push(1'b0, 3, "R8");
        push(1'b1, 4, "R8");
        push(1'b0, 5, "R8");
        adv(2);
        fall_trig = 1'b1;
        adv(1);
        width_in = 8'd0;
        adv(1);
        fall_trig = 1'b0;
        adv(8);
        rest(4);

        // R11: asynchronous reset in the middle of a pulse
        width_in  = 8'd20;
        rise_trig = 1'b1;
        push(1'b0, 4, "R11");
        adv(4);
        fall_trig = 1'b0;
        push(1'b0, 3, "R11");
        push(1'b1, 2, "R11");
        adv(5);
        rst_n = 1'b0;
        #2;
        checks++;
        if (q_out !== 1'b0 || qn_out !== 1'b1) begin
            errors++;
            $display("FAIL R11 async reset q=%b qn=%b expected 0 1", q_out, qn_out);
        end
        adv(2);
        summary();
    end

endmodule